// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block produces the raster timing for a display interface. A horizontal counter, a line counter and a frame-clock counter run in the pixel clock domain. From the programmed sync widths, porches, sizes and skew the block decodes five outputs: horizontal sync, vertical sync, a display-window enable, an active-window enable and a data-valid enable. The data-valid window is kept apart from the active window so that a downstream stage can fetch at a different rate from the video timing.

Two mode bits reshape the timing. In wide-bus mode two pixels move per clock. When wide-bus is combined with the port-style mode, the block halves the five horizontal pixel terms itself. When wide-bus is used without that mode, only the data-valid window is halved. The port-style mode moves the frame-level display window so that it starts and ends on active pixel columns rather than on line starts.

Software writes timing values into shadow registers through a simple write port. A small state machine with the states IDLE, LOAD and RUN copies them into a working threshold set at enable and at every frame wrap. Its transitions are IDLE to LOAD when the enable bit is seen, LOAD to RUN after one cycle, RUN to RUN with a reload at the frame wrap, and any state to IDLE when the enable bit is clear.

Top module: `vid_timing_gen`

## Requirements
- R1: Let hc = hsync width + h back porch + width + h front porch. The horizontal counter runs 0 to hc−1. A frame lasts (vsync width + v back porch + height + v front porch) lines, after which all counters return to zero together.
- R2: hsync is asserted for the first (effective) hsync-width clocks of each line, and vsync for the first vsync-width lines of each frame. Control bit 1 inverts hsync and control bit 2 inverts vsync. Both bits act at once, even while the block is idle.
- R3: Outside the port-style mode, the display enable is high when two conditions hold. The column must lie in [hsw+hbp, hc−hfp−1]. The frame clock f must lie in [(vsw+vbp)·hc+skew, (lines−vfp)·hc+skew−1].
- R4: In the port-style mode, the frame-level display start is later by hsw+hbp and the frame-level display end is earlier by hfp. The display column range becomes the active column range.
- R5: The active enable is high when the column lies in [hsw+hbp, hsw+hbp+xres−1] and f lies in [display start, display start + yres·hc − 1].
- R6: The data-valid enable uses the active frame range and the columns [hsw+hbp, hsw+hbp+dw−1]. dw is width>>1 when wide-bus is on and the port-style mode is off; otherwise dw is the effective width.
- R7: With wide-bus and the port-style mode both on, hsw, hbp, width, hfp and xres are each shifted right by one before any other use.
- R8: Timing words written while running take effect only at the next frame start, so a frame never mixes two settings.
- R9: Control bit 0 enables the block. While it is clear, all counters are zero, the enables are low and the syncs sit at their inactive levels. After it is set, one IDLE cycle and one LOAD cycle pass, and the next cycle is frame clock 0.
- R10: The write map is as follows. Address 0 holds the control bits. Address 1 holds hsw in [15:0] and hbp in [31:16]. Address 2 holds width in [15:0] and hfp in [31:16]. Address 3 holds vsw in [15:0] and vbp in [31:16]. Address 4 holds height in [15:0] and vfp in [31:16]. Address 5 holds xres in [15:0] and yres in [31:16]. Address 6 holds skew in [15:0], wide-bus in bit 16 and the port-style mode in bit 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| disp_en_o | output | 1 | Display-window enable |
| act_en_o | output | 1 | Active-window enable |
| data_en_o | output | 1 | Data-valid enable |

## Verification
The assertions check the following on every cycle: the line wrap, the frame clock advancing by one between wraps, the working thresholds holding steady except at a frame wrap, and counters zero with quiet outputs whenever the enable is clear. The exact edge positions of every window, the odd-value halving and the deferred effect of a mid-frame write only show up in the bench's scenarios. There, each output is compared cycle by cycle against an arithmetic model for plain, port-style, wide-bus, combined, inverted-polarity and shadow-update settings.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
    localparam int unsigned HW = 16;   // horizontal/vertical term width
    localparam int unsigned FW = 32;   // frame-clock counter width
    localparam int unsigned AW = 3;    // register address width
    localparam int unsigned DW = 32;   // register data width
    localparam int unsigned HI = 16;   // upper field offset in a data word

    localparam logic [AW-1:0] A_CTRL  = 3'd0;
    localparam logic [AW-1:0] A_HSYNC = 3'd1;
    localparam logic [AW-1:0] A_HSIZE = 3'd2;
    localparam logic [AW-1:0] A_VSYNC = 3'd3;
    localparam logic [AW-1:0] A_VSIZE = 3'd4;
    localparam logic [AW-1:0] A_ACT   = 3'd5;
    localparam logic [AW-1:0] A_MODE  = 3'd6;

    typedef enum logic [1:0] {S_IDLE, S_LOAD, S_RUN} vtg_state_e;

    typedef struct packed {
        logic [HW-1:0] hsw, hbp, wid, hfp;
        logic [HW-1:0] vsw, vbp, hgt, vfp;
        logic [HW-1:0] xres, yres, skew;
        logic          wide, dp;
    } vtg_cfg_t;

    typedef struct packed {
        logic [HW-1:0] hp, vt, hsw, vsw;
        logic [HW-1:0] hds, dhe, ahe, dte;
        logic [FW-1:0] fds, fde, afe;
    } vtg_thr_t;
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
    import vtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output vtg_cfg_t      shadow_o,
    output logic          en_o,
    output logic          hinv_o,
    output logic          vinv_o
);
    logic [HW-1:0] lo_f, hi_f;
    assign lo_f = wr_data[HW-1:0];
    assign hi_f = wr_data[HI+HW-1:HI];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_o <= '0;
            en_o     <= 1'b0;
            hinv_o   <= 1'b0;
            vinv_o   <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL:  begin
                    en_o   <= wr_data[0];
                    hinv_o <= wr_data[1];
                    vinv_o <= wr_data[2];
                end
                A_HSYNC: begin shadow_o.hsw  <= lo_f; shadow_o.hbp  <= hi_f; end
                A_HSIZE: begin shadow_o.wid  <= lo_f; shadow_o.hfp  <= hi_f; end
                A_VSYNC: begin shadow_o.vsw  <= lo_f; shadow_o.vbp  <= hi_f; end
                A_VSIZE: begin shadow_o.hgt  <= lo_f; shadow_o.vfp  <= hi_f; end
                A_ACT:   begin shadow_o.xres <= lo_f; shadow_o.yres <= hi_f; end
                A_MODE:  begin
                    shadow_o.skew <= lo_f;
                    shadow_o.wide <= wr_data[HI];
                    shadow_o.dp   <= wr_data[HI+1];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/vtg_calc.sv
module vtg_calc
    import vtg_pkg::*;
(
    input  vtg_cfg_t cfg_i,
    output vtg_thr_t thr_o
);
    localparam logic [HW-1:0] ONE_H = 1;
    localparam logic [FW-1:0] ONE_F = 1;

    logic          halve;
    logic [HW-1:0] e_hsw, e_hbp, e_wid, e_hfp, e_xres, dw;

    // R7: wide-bus plus port-style mode halves the horizontal pixel terms
    assign halve  = cfg_i.wide & cfg_i.dp;
    assign e_hsw  = halve ? (cfg_i.hsw  >> 1) : cfg_i.hsw;
    assign e_hbp  = halve ? (cfg_i.hbp  >> 1) : cfg_i.hbp;
    assign e_wid  = halve ? (cfg_i.wid  >> 1) : cfg_i.wid;
    assign e_hfp  = halve ? (cfg_i.hfp  >> 1) : cfg_i.hfp;
    assign e_xres = halve ? (cfg_i.xres >> 1) : cfg_i.xres;
    // R6: wide-bus without the port-style mode halves only the data window
    assign dw     = (cfg_i.wide && !cfg_i.dp) ? (cfg_i.wid >> 1) : e_wid;

    always_comb begin
        thr_o.hp  = e_hsw + e_hbp + e_wid + e_hfp;
        thr_o.vt  = cfg_i.vsw + cfg_i.vbp + cfg_i.hgt + cfg_i.vfp;
        thr_o.hsw = e_hsw;
        thr_o.vsw = cfg_i.vsw;
        thr_o.hds = e_hsw + e_hbp;
        thr_o.ahe = thr_o.hds + e_xres - ONE_H;
        thr_o.dte = thr_o.hds + dw - ONE_H;
        thr_o.dhe = cfg_i.dp ? thr_o.ahe : (thr_o.hp - e_hfp - ONE_H);
        thr_o.fds = FW'(cfg_i.vsw + cfg_i.vbp) * FW'(thr_o.hp) + FW'(cfg_i.skew);
        thr_o.fde = FW'(thr_o.vt - cfg_i.vfp) * FW'(thr_o.hp) + FW'(cfg_i.skew) - ONE_F;
        if (cfg_i.dp) begin
            thr_o.fds = thr_o.fds + FW'(thr_o.hds);
            thr_o.fde = thr_o.fde - FW'(e_hfp);
        end
        thr_o.afe = thr_o.fds + FW'(cfg_i.yres) * FW'(thr_o.hp) - ONE_F;
    end
endmodule

// File: rtl/vtg_core.sv
module vtg_core
    import vtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  vtg_thr_t      thr_next_i,
    output vtg_state_e    st_o,
    output logic [HW-1:0] hpos_o,
    output logic [HW-1:0] vline_o,
    output logic [FW-1:0] fpos_o,
    output vtg_thr_t      thr_o
);
    localparam logic [HW-1:0] ONE_H = 1;
    localparam logic [FW-1:0] ONE_F = 1;

    vtg_state_e st_n;
    logic       line_end, wrap, adv;

    assign line_end = (hpos_o == thr_o.hp - ONE_H);
    assign wrap     = line_end && (vline_o == thr_o.vt - ONE_H);
    assign adv      = en_i && (st_o == S_RUN);

    always_comb begin
        st_n = st_o;
        if (!en_i) begin
            st_n = S_IDLE;
        end else begin
            unique case (st_o)
                S_IDLE: st_n = S_LOAD;
                S_LOAD: st_n = S_RUN;
                S_RUN:  st_n = S_RUN;
                default: st_n = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_o <= S_IDLE;
        else        st_o <= st_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hpos_o  <= '0;
            vline_o <= '0;
            fpos_o  <= '0;
            thr_o   <= '0;
        end else if (!adv) begin
            hpos_o  <= '0;
            vline_o <= '0;
            fpos_o  <= '0;
            if (en_i && st_o == S_LOAD) thr_o <= thr_next_i;
        end else if (wrap) begin
            hpos_o  <= '0;
            vline_o <= '0;
            fpos_o  <= '0;
            thr_o   <= thr_next_i;
        end else begin
            fpos_o <= fpos_o + ONE_F;
            if (line_end) begin
                hpos_o  <= '0;
                vline_o <= vline_o + ONE_H;
            end else begin
                hpos_o <= hpos_o + ONE_H;
            end
        end
    end

    p_line_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && line_end) |=> (hpos_o == '0));
    p_fclk_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wrap) |=> (fpos_o == $past(fpos_o) + ONE_F));
    p_thr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wrap) |=> $stable(thr_o));
    p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (hpos_o == '0 && vline_o == '0 && fpos_o == '0));
    p_load_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_o == S_LOAD) |-> (hpos_o == '0 && fpos_o == '0));
endmodule

// File: rtl/vid_timing_gen.sv
module vid_timing_gen
    import vtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          disp_en_o,
    output logic          act_en_o,
    output logic          data_en_o
);
    vtg_cfg_t      shadow;
    vtg_thr_t      thr_next, thr;
    vtg_state_e    st;
    logic          en, hinv, vinv, run;
    logic [HW-1:0] hpos, vline;
    logic [FW-1:0] fpos;
    logic          fv_disp, fv_act, h_disp, h_act, h_data;

    vtg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .shadow_o(shadow), .en_o(en),
        .hinv_o(hinv), .vinv_o(vinv)
    );

    vtg_calc u_calc (.cfg_i(shadow), .thr_o(thr_next));

    vtg_core u_core (
        .clk(clk), .rst_n(rst_n), .en_i(en), .thr_next_i(thr_next),
        .st_o(st), .hpos_o(hpos), .vline_o(vline), .fpos_o(fpos), .thr_o(thr)
    );

    always_comb begin
        run       = en && (st == S_RUN);
        fv_disp   = (fpos >= thr.fds) && (fpos <= thr.fde);
        fv_act    = (fpos >= thr.fds) && (fpos <= thr.afe);
        h_disp    = (hpos >= thr.hds) && (hpos <= thr.dhe);
        h_act     = (hpos >= thr.hds) && (hpos <= thr.ahe);
        h_data    = (hpos >= thr.hds) && (hpos <= thr.dte);
        hsync_o   = (run && (hpos  < thr.hsw)) ^ hinv;
        vsync_o   = (run && (vline < thr.vsw)) ^ vinv;
        disp_en_o = run && fv_disp && h_disp;
        act_en_o  = run && fv_act  && h_act;
        data_en_o = run && fv_act  && h_data;
    end

    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!disp_en_o && !act_en_o && !data_en_o
                 && hsync_o == hinv && vsync_o == vinv));
endmodule

// File: tb/vid_timing_gen_tb.sv
module vid_timing_gen_tb;
    typedef struct {
        int hsw, hbp, wid, hfp, vsw, vbp, hgt, vfp, xres, yres, skew;
        bit wide, dp;
    } tcfg_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        hsync_o, vsync_o, disp_en_o, act_en_o, data_en_o;

    int total = 0;
    int bad = 0;
    bit hinv = 0, vinv = 0;
    tcfg_t cur, nxt;

    always #2 clk = ~clk;   // 250 MHz

    vid_timing_gen u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hsync_o(hsync_o), .vsync_o(vsync_o),
        .disp_en_o(disp_en_o), .act_en_o(act_en_o), .data_en_o(data_en_o)
    );

    task automatic chk(input logic got, input logic exp, input string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0b expected %0b", what, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] pk(input int lo, input int hi);
        return {hi[15:0], lo[15:0]};
    endfunction

    // R10: register map used by every scenario
    task automatic load(input tcfg_t c);
        wr(3'd1, pk(c.hsw, c.hbp));
        wr(3'd2, pk(c.wid, c.hfp));
        wr(3'd3, pk(c.vsw, c.vbp));
        wr(3'd4, pk(c.hgt, c.vfp));
        wr(3'd5, pk(c.xres, c.yres));
        wr(3'd6, {14'd0, c.dp, c.wide, c.skew[15:0]});
    endtask

    task automatic quiet(input string tag);
        chk(hsync_o, hinv, {tag, " R9 R2 hsync idle level"});
        chk(vsync_o, vinv, {tag, " R9 R2 vsync idle level"});
        chk(disp_en_o, 1'b0, {tag, " R9 display idle"});
        chk(act_en_o, 1'b0, {tag, " R9 active idle"});
        chk(data_en_o, 1'b0, {tag, " R9 data idle"});
    endtask

    function automatic int frame_len(input tcfg_t c);
        int s;
        s = (c.wide && c.dp) ? 1 : 0;
        return ((c.hsw >> s) + (c.hbp >> s) + (c.wid >> s) + (c.hfp >> s))
               * (c.vsw + c.vbp + c.hgt + c.vfp);
    endfunction

    // bits: {hsync, vsync, display, active, data}
    function automatic logic [4:0] model(input tcfg_t c, input int f);
        int s, ehsw, ehbp, ewid, ehfp, ex, hp, vt, h, l;
        int hds, hde, fds, fde, afe, ahe, dw, dte;
        logic [4:0] r;
        s    = (c.wide && c.dp) ? 1 : 0;         // R7
        ehsw = c.hsw >> s; ehbp = c.hbp >> s; ewid = c.wid >> s;
        ehfp = c.hfp >> s; ex = c.xres >> s;
        hp   = ehsw + ehbp + ewid + ehfp;        // R1
        vt   = c.vsw + c.vbp + c.hgt + c.vfp;
        h    = f % hp; l = f / hp;
        hds  = ehsw + ehbp;
        ahe  = hds + ex - 1;
        hde  = c.dp ? ahe : hp - ehfp - 1;       // R3 R4
        fds  = (c.vsw + c.vbp) * hp + c.skew + (c.dp ? hds : 0);
        fde  = (vt - c.vfp) * hp + c.skew - 1 - (c.dp ? ehfp : 0);
        afe  = fds + c.yres * hp - 1;            // R5
        dw   = (c.wide && !c.dp) ? (c.wid >> 1) : ewid;  // R6
        dte  = hds + dw - 1;
        r[4] = (h < ehsw) ^ hinv;                // R2
        r[3] = (l < c.vsw) ^ vinv;
        r[2] = (f >= fds) && (f <= fde) && (h >= hds) && (h <= hde);
        r[1] = (f >= fds) && (f <= afe) && (h >= hds) && (h <= ahe);
        r[0] = (f >= fds) && (f <= afe) && (h >= hds) && (h <= dte);
        return r;
    endfunction

    // enable; two quiet cycles (IDLE, LOAD), then frame clock 0 follows
    task automatic start(input string tag);
        wr(3'd0, {29'd0, vinv, hinv, 1'b1});
        quiet({tag, " IDLE"});
        @(negedge clk);
        quiet({tag, " LOAD"});
    endtask

    task automatic stop(input string tag);
        wr(3'd0, {29'd0, vinv, hinv, 1'b0});
        quiet(tag);
        @(negedge clk);
        quiet(tag);
    endtask

    // compare every cycle; optionally write address 1 mid-frame
    task automatic run(input int n, input string tag, input int chg_at,
                       input logic [31:0] chg_data);
        int f;
        logic [4:0] e;
        f = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            e = model(cur, f);
            chk(hsync_o,   e[4], $sformatf("%s R2 hsync f=%0d", tag, f));
            chk(vsync_o,   e[3], $sformatf("%s R2 vsync f=%0d", tag, f));
            chk(disp_en_o, e[2], $sformatf("%s R3 R4 display f=%0d", tag, f));
            chk(act_en_o,  e[1], $sformatf("%s R5 active f=%0d", tag, f));
            chk(data_en_o, e[0], $sformatf("%s R6 data f=%0d", tag, f));
            if (i == chg_at) begin
                wr_en = 1'b1; wr_addr = 3'd1; wr_data = chg_data;
            end
            if (i == chg_at + 1) wr_en = 1'b0;
            f++;
            if (f == frame_len(cur)) begin   // R1 wrap, R8 reload point
                f = 0;
                cur = nxt;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tcfg_t a, b, c, d, s;
        a = '{hsw:2, hbp:3, wid:8, hfp:2, vsw:1, vbp:2, hgt:4, vfp:1,
              xres:6, yres:3, skew:1, wide:0, dp:0};
        b = '{hsw:2, hbp:3, wid:8, hfp:3, vsw:2, vbp:1, hgt:4, vfp:2,
              xres:8, yres:4, skew:0, wide:0, dp:1};
        c = a; c.wide = 1;
        d = '{hsw:3, hbp:5, wid:10, hfp:3, vsw:1, vbp:1, hgt:3, vfp:1,
              xres:9, yres:2, skew:2, wide:1, dp:1};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        quiet("reset");

        // R1 R3 R5: plain mode, two frames across the wrap
        load(a); cur = a; nxt = a;
        start("plain");
        run(2 * frame_len(a) + 3, "R1 plain", -5, 32'd0);
        stop("R9 clear");

        // R4: port-style mode with odd front porch
        load(b); cur = b; nxt = b;
        start("dp");
        run(frame_len(b) + 3, "R4 dp", -5, 32'd0);
        stop("R9 clear");

        // R6: wide-bus without port-style mode halves only the data window
        load(c); cur = c; nxt = c;
        start("wide");
        run(frame_len(c) + 3, "R6 wide", -5, 32'd0);
        stop("R9 clear");

        // R7: wide-bus plus port-style mode, odd values shifted down
        load(d); cur = d; nxt = d;
        start("widedp");
        run(frame_len(d) + 3, "R7 wide+dp", -5, 32'd0);

        // R2: inverted polarity, applied at once while idle
        hinv = 1; vinv = 1;
        stop("R2 inverted idle");
        load(a); cur = a; nxt = a;
        start("inv");
        run(frame_len(a) + 3, "R2 inverted", -5, 32'd0);
        hinv = 0; vinv = 0;
        stop("R9 clear");

        // R8: mid-frame write of hsw=3 hbp=4 lands at the next frame start
        load(a); cur = a; nxt = a;
        start("shadow");
        s = a; s.hsw = 3; s.hbp = 4; nxt = s;
        run(frame_len(a) + frame_len(s) + 3, "R8 shadow", 40, pk(3, 4));
        stop("R9 clear");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule